// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block watches a switch matrix of up to 8 rows by 10 columns and reports each key closing and opening as a one-byte event. While nothing is pressed it pulls every enabled column low and waits for an enabled row to fall. A falling row starts a scan. The scan drives each column low in turn, lets the lines settle, and then reads the rows. After that first scan, the block scans once on every pulse of a sample tick. In the product that tick arrives every 25 ms; a bench can use a much shorter one.

A key change is accepted only after two scans in a row agree. A press is therefore reported on the second scan that finds the key closed. A release is reported on the second scan that finds it open, so release latency lies between one and two tick periods. Events leave through a valid/ready handshake, and the scan waits while the receiver holds ready low. Per-pin enable masks choose which rows and columns belong to the matrix. Once every key has been reported released, the block returns to its quiet state.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, and whenever the block is quiet, `col_drive` equals `col_en` and `evt_valid` is low.
- R2: Outside the quiet state at most one column is driven at a time, and only an enabled one. Rows are read only after that column has been driven for `SETTLE` clocks.
- R3: In the quiet state, a low level on any enabled row starts a scan on the next clock edge, beginning with column 0.
- R4: A press event is emitted only when two consecutive scans both find the key closed. A closure seen on a single scan produces no event.
- R5: A key held closed across any number of further scans produces no further press events.
- R6: A release event is emitted only on the second consecutive scan that finds a pressed key open. The first open scan produces no event.
- R7: `evt_data[7]` is 1 for a press and 0 for a release. `evt_data[6:0]` is row*10 + column + 1, so it lies in the range 1 to 80.
- R8: Events found in the same scan come out in ascending column order, and in ascending row order within one column.
- R9: A disabled column is never driven, and a closure on a disabled row or column causes neither a scan start nor an event.
- R10: While `evt_valid` is high and `evt_ready` is low, `evt_valid` stays high and `evt_data` stays unchanged.
- R11: After the scan that reports the last open key, the block returns to the quiet state with all enabled columns driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_en | input | ROWS | Row belongs to the matrix when 1 |
| col_en | input | COLS | Column belongs to the matrix when 1 |
| row_in | input | ROWS | Debounced row levels; low means the row is pulled down through a key |
| tick | input | 1 | One-clock sample pulse that sets the scan period |
| col_drive | output | COLS | 1 drives the column low; 0 leaves it high-Z |
| evt_valid | output | 1 | Event byte is valid |
| evt_ready | input | 1 | Receiver accepts the event |
| evt_data | output | 8 | Bit 7 is the press flag; bits 6:0 are the key number |

## Verification
Some rules are checked on every clock cycle. These are the column-drive rules: all enabled columns while quiet, at most one enabled column during a scan, and never a disabled column. The other per-cycle checks are the range of the key number and the holding of a stalled event. Some behaviour can only be shown by the bench's scenarios. This covers the two-scan acceptance for presses and releases, the absence of repeats while a key is held, and the order of several events in one scan. It also covers the silence of masked pins and the return to quiet after the last release. In these scenarios a matrix model pulls rows low through closed keys on driven columns, and a scoreboard compares every accepted event with its expected value.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;
  typedef enum logic [2:0] {
    KS_IDLE,
    KS_SETTLE,
    KS_EMIT,
    KS_DONE,
    KS_WAIT
  } ks_state_t;
endpackage

// File: rtl/kscan_col_drive.sv
module kscan_col_drive #(
  parameter int COLS = 10,
  parameter int CW   = 4
) (
  input  logic            all_on,
  input  logic            scan_on,
  input  logic [CW-1:0]   col_idx,
  input  logic [COLS-1:0] col_en,
  output logic [COLS-1:0] col_drive
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_drive[c] = col_en[c] & (all_on | (scan_on & (col_idx == CW'(c))));
  end
endmodule

// File: rtl/kscan_key_table.sv
module kscan_key_table #(
  parameter int NKEYS = 80,
  parameter int IW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  logic          wr_en,
  input  logic          wr_pressed,
  input  logic          wr_pend,
  output logic          rd_pressed,
  output logic          rd_pend,
  output logic          any_active
);
  logic [NKEYS-1:0] pressed_q;
  logic [NKEYS-1:0] pend_q;

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pressed_q[k] <= 1'b0;
        pend_q[k]    <= 1'b0;
      end else if (wr_en && (idx == IW'(k))) begin
        pressed_q[k] <= wr_pressed;
        pend_q[k]    <= wr_pend;
      end
    end
  end

  assign rd_pressed = pressed_q[idx];
  assign rd_pend    = pend_q[idx];
  assign any_active = |(pressed_q | pend_q);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS   = 8,
  parameter int COLS   = 10,
  parameter int SETTLE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_en,
  input  logic [COLS-1:0] col_en,
  input  logic [ROWS-1:0] row_in,
  input  logic            tick,
  output logic [COLS-1:0] col_drive,
  output logic            evt_valid,
  input  logic            evt_ready,
  output logic [7:0]      evt_data
);
  import keypad_scan_pkg::*;

  localparam int NKEYS = ROWS * COLS;
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int IW    = 7;
  localparam int SW    = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  ks_state_t       st_q, st_n;
  logic [CW-1:0]   col_q, col_n;
  logic [RW-1:0]   row_q, row_n;
  logic [SW-1:0]   set_q, set_n;
  logic [ROWS-1:0] samp_q, samp_n;
  logic            tick_q, tick_n;

  logic [IW-1:0]   key_idx;
  logic            closed, differ, fire, advance;
  logic            rd_pressed, rd_pend, any_active;
  logic            wr_pressed, wr_pend;
  logic            row_hit;

  assign key_idx = IW'(row_q) * IW'(COLS) + IW'(col_q);
  assign closed  = samp_q[row_q];
  assign differ  = closed != rd_pressed;
  assign fire    = (st_q == KS_EMIT) && differ && rd_pend;
  assign advance = (st_q == KS_EMIT) && (!fire || evt_ready);
  assign row_hit = |(~row_in & row_en);

  assign wr_pressed = fire ? closed : rd_pressed;
  assign wr_pend    = differ && !rd_pend;

  assign evt_valid = fire;
  assign evt_data  = {closed, key_idx + 7'd1};

  kscan_key_table #(.NKEYS(NKEYS), .IW(IW)) u_keys (
    .clk        (clk),
    .rst_n      (rst_s),
    .idx        (key_idx),
    .wr_en      (advance),
    .wr_pressed (wr_pressed),
    .wr_pend    (wr_pend),
    .rd_pressed (rd_pressed),
    .rd_pend    (rd_pend),
    .any_active (any_active)
  );

  kscan_col_drive #(.COLS(COLS), .CW(CW)) u_cols (
    .all_on    (st_q == KS_IDLE),
    .scan_on   ((st_q == KS_SETTLE) || (st_q == KS_EMIT)),
    .col_idx   (col_q),
    .col_en    (col_en),
    .col_drive (col_drive)
  );

  // next state
  always_comb begin
    st_n   = st_q;
    col_n  = col_q;
    row_n  = row_q;
    set_n  = set_q;
    samp_n = samp_q;
    tick_n = (st_q == KS_IDLE) ? 1'b0 : (tick_q | tick);
    unique case (st_q)
      KS_IDLE: begin
        if (row_hit) begin
          st_n  = KS_SETTLE;
          col_n = '0;
          set_n = '0;
        end
      end
      KS_SETTLE: begin
        if (set_q == SW'(SETTLE - 1)) begin
          samp_n = ~row_in & row_en;
          row_n  = '0;
          st_n   = KS_EMIT;
        end else begin
          set_n = set_q + 1'b1;
        end
      end
      KS_EMIT: begin
        if (advance) begin
          if (row_q == RW'(ROWS - 1)) begin
            if (col_q == CW'(COLS - 1)) begin
              st_n = KS_DONE;
            end else begin
              col_n = col_q + 1'b1;
              set_n = '0;
              st_n  = KS_SETTLE;
            end
          end else begin
            row_n = row_q + 1'b1;
          end
        end
      end
      KS_DONE: begin
        st_n = any_active ? KS_WAIT : KS_IDLE;
      end
      KS_WAIT: begin
        if (tick_q || tick) begin
          st_n   = KS_SETTLE;
          col_n  = '0;
          set_n  = '0;
          tick_n = 1'b0;
        end
      end
      default: st_n = KS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= KS_IDLE;
      col_q  <= '0;
      row_q  <= '0;
      set_q  <= '0;
      samp_q <= '0;
      tick_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      col_q  <= col_n;
      row_q  <= row_n;
      set_q  <= set_n;
      samp_q <= samp_n;
      tick_q <= tick_n;
    end
  end
endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            idle,
  input logic [COLS-1:0] col_en,
  input logic [COLS-1:0] col_drive,
  input logic            evt_valid,
  input logic            evt_ready,
  input logic [7:0]      evt_data
);
  a_r1_idle_drive: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (col_drive == col_en) && !evt_valid);

  a_r2_single_column: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> $onehot0(col_drive));

  a_r9_no_disabled_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (col_drive & ~col_en) == '0);

  a_r7_key_range: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_data[6:0] >= 7'd1) && (int'(evt_data[6:0]) <= ROWS * COLS));

  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> evt_valid && $stable(evt_data));
endmodule

bind keypad_scanner keypad_scanner_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idle      (st_q == keypad_scan_pkg::KS_IDLE),
  .col_en    (col_en),
  .col_drive (col_drive),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_data  (evt_data)
);

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;
  localparam int ROWS = 8;
  localparam int COLS = 10;
  localparam int NK   = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [ROWS-1:0] row_en;
  logic [COLS-1:0] col_en;
  logic [ROWS-1:0] row_in;
  logic            tick;
  logic [COLS-1:0] col_drive;
  logic            evt_valid;
  logic            evt_ready;
  logic [7:0]      evt_data;
  logic [NK-1:0]   keys;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  keypad_scanner u_keypad_scanner (
    .clk(clk), .rst_n(rst_n), .row_en(row_en), .col_en(col_en),
    .row_in(row_in), .tick(tick), .col_drive(col_drive),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data)
  );

  // matrix model: a row is pulled low through a closed key on a driven column
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_in[r] = 1'b1;
      for (int c = 0; c < COLS; c++)
        if (keys[r*COLS+c] && col_drive[c]) row_in[r] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected events as the design hands them over
  always @(negedge clk) begin
    if (rst_n && evt_valid && evt_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R6 unexpected event", int'(evt_data), 0);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(evt_data == e, t, int'(evt_data), int'(e));
      end
    end
  end

  task automatic expect_evt(input logic [7:0] d, input string t);
    exp_q.push_back(d);
    tag_q.push_back(t);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_tick();
    @(posedge clk); #1 tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
  endtask

  task automatic scan_tick();
    pulse_tick();
    wait_cyc(300);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  function automatic int kidx(input int r, input int c);
    return r * COLS + c;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; evt_ready = 1'b1;
    row_en = '1; col_en = '1; keys = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1: reset state
    check(col_drive == col_en, "R1 reset drive", int'(col_drive), int'(col_en));
    check(evt_valid == 1'b0, "R1 reset valid", int'(evt_valid), 0);

    // single key row 2 col 3 -> key 24
    keys[kidx(2,3)] = 1'b1;
    @(posedge clk); @(negedge clk);
    check(col_drive == 10'b1, "R3 scan starts at column 0", int'(col_drive), 1);
    wait_cyc(300);
    drained("R4 no event after first closed scan");
    expect_evt(8'h98, "R4/R7 press key 24");
    scan_tick();
    drained("R4 press after second scan");
    scan_tick(); scan_tick(); scan_tick();
    drained("R5 no repeat while held");
    keys[kidx(2,3)] = 1'b0;
    scan_tick();
    drained("R6 no release after first open scan");
    expect_evt(8'h18, "R6/R7 release key 24");
    scan_tick();
    drained("R6 release after second open scan");
    check(col_drive == col_en, "R11 back to quiet", int'(col_drive), int'(col_en));

    // glitch: closed for one scan only, key 47
    keys[kidx(4,6)] = 1'b1;
    wait_cyc(300);
    keys[kidx(4,6)] = 1'b0;
    scan_tick();
    drained("R4 single-scan closure ignored");
    check(col_drive == col_en, "R11 quiet after glitch", int'(col_drive), int'(col_en));

    // several keys in one scan: keys 1, 52, 80
    keys[kidx(0,0)] = 1'b1; keys[kidx(5,1)] = 1'b1; keys[kidx(7,9)] = 1'b1;
    wait_cyc(300);
    expect_evt(8'h81, "R8 press order key 1");
    expect_evt(8'hB4, "R8 press order key 52");
    expect_evt(8'hD0, "R8 press order key 80");
    scan_tick();
    drained("R8 all presses seen");
    keys = '0;
    scan_tick();
    expect_evt(8'h01, "R8 release order key 1");
    expect_evt(8'h34, "R8 release order key 52");
    expect_evt(8'h50, "R8 release order key 80");
    scan_tick();
    drained("R8 all releases seen");
    check(col_drive == col_en, "R11 quiet after multi", int'(col_drive), int'(col_en));

    // masked pins: column 4 and row 6 disabled
    col_en[4] = 1'b0; row_en[6] = 1'b0;
    keys[kidx(1,4)] = 1'b1; keys[kidx(6,2)] = 1'b1;
    wait_cyc(300);
    check(col_drive == col_en, "R9 no scan from masked pins", int'(col_drive), int'(col_en));
    scan_tick(); scan_tick();
    drained("R9 no event from masked pins");
    check(col_drive[4] == 1'b0, "R9 disabled column not driven", int'(col_drive[4]), 0);
    keys = '0; col_en = '1; row_en = '1;
    wait_cyc(10);

    // stall: key row 3 col 8 -> 39
    evt_ready = 1'b0;
    keys[kidx(3,8)] = 1'b1;
    wait_cyc(300);
    expect_evt(8'hA7, "R10 stalled press key 39");
    pulse_tick();
    wait_cyc(150);
    check(evt_valid == 1'b1, "R10 valid held while stalled", int'(evt_valid), 1);
    check(evt_data == 8'hA7, "R10 data held while stalled", int'(evt_data), 'hA7);
    wait_cyc(20);
    check(evt_valid == 1'b1 && evt_data == 8'hA7, "R10 still held", int'(evt_data), 'hA7);
    evt_ready = 1'b1;
    wait_cyc(200);
    drained("R10 stalled event delivered");
    keys = '0;
    scan_tick();
    expect_evt(8'h27, "R6 release key 39");
    scan_tick();
    drained("R6 release key 39 seen");
    check(col_drive == col_en, "R11 quiet at end", int'(col_drive), int'(col_en));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule